// File: doc/BRIEF.md
# DMA Request Sampling Controller

This block watches an external DMA request line for one channel and decides the clock cycle in which each transfer begins. Sampling runs one transfer ahead of the bus. After a request is first seen, the transfer starts three cycles later and the next sample is taken two cycles after the first. If that sample finds nothing, the line is polled every cycle. Once a request for the following transfer is held, sampling pauses until the idle cycle after the current bus cycle completes. Detection can be level or rising edge. Cycle-steal mode and burst mode with level detection share this schedule. Burst mode with edge detection samples once and then runs the whole programmed count back to back.

The bus cycle is modelled as a start/done handshake. `xfer_start_o` pulses for one cycle, the bus then asserts `cs_i` for the DMA access, and it pulses `bus_done_i` in the last cycle of that access. The acknowledge output follows the chip-select for exactly that access. A transfer counter is loaded with `count_load_i`; the channel stops when the count reaches zero. An NMI suspends the channel and sets an internal suspend flag. Clearing the flag with `flag_clr_i` re-arms sampling, but only a fresh rising edge restarts transfers.

Top module: `dma_req_sampler`

## Requirements
- R1: While armed, a sample in level mode detects a request when `dreq_i` is high in that cycle. In edge mode it detects one when `dreq_i` is high and was low in the previous cycle.
- R2: A sample that detects a request while no transfer is pending or on the bus produces a one-cycle `xfer_start_o` pulse exactly three cycles later.
- R3: The second sample is taken two cycles after the first. If it misses, sampling repeats every cycle, and a later hit with the bus idle again starts a transfer three cycles after that sample.
- R4: A request detected while a transfer is pending or active is held, and sampling stops until the cycle after that transfer's `bus_done_i`. The held transfer starts two cycles after `bus_done_i`, so a constantly high level request gives starts spaced bus length plus two cycles apart.
- R5: The sampling and start schedule depends on the bus cycle length only through the `bus_done_i` timing given in R4.
- R6: Burst mode (`burst_mode_i`=1) with level detection (`edge_mode_i`=0) behaves exactly like cycle-steal mode.
- R7: In burst mode with edge detection, one rising edge starts all remaining transfers. Each transfer after the first starts two cycles after the previous `bus_done_i`, whatever `dreq_i` does.
- R8: In cycle-steal mode with edge detection, a request held high yields no further transfers; each transfer needs its own rising edge.
- R9: `ack_o` equals `cs_i` from the cycle after `xfer_start_o` through the cycle of `bus_done_i`, and is low at all other times.
- R10: A `count_load_i` pulse with nonzero `count_i` arms the channel. `busy_o` is high while the count is nonzero and the channel is not suspended. Each accepted `bus_done_i` decrements the count.
- R11: The `bus_done_i` that takes the count to zero causes a one-cycle `done_o` pulse in the next cycle and drops `busy_o`. No further transfer starts until a reload.
- R12: An `nmi_i` cycle suspends the channel. No transfer starts afterwards, a bus cycle already underway completes, any held request is discarded, `busy_o` drops, and requests are ignored while suspended.
- R13: A `flag_clr_i` pulse lifts the suspension and `busy_o` returns if count remains. A request already held high does not restart; the next rising edge does.
- R14: After reset `xfer_start_o`, `ack_o`, `busy_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dreq_i | input | 1 | External DMA request line |
| burst_mode_i | input | 1 | 1 = burst mode, 0 = cycle-steal mode |
| edge_mode_i | input | 1 | 1 = rising-edge detection, 0 = level detection |
| count_load_i | input | 1 | Load strobe for the transfer count |
| count_i | input | CNT_W | Transfer count to load |
| bus_done_i | input | 1 | Last cycle of the DMA bus access |
| cs_i | input | 1 | Bus chip-select |
| nmi_i | input | 1 | Non-maskable interrupt, suspends the channel |
| flag_clr_i | input | 1 | Clears the suspend flag |
| xfer_start_o | output | 1 | One-cycle transfer start pulse |
| ack_o | output | 1 | DMA acknowledge, follows chip-select of the DMA access |
| busy_o | output | 1 | Channel armed with count remaining and not suspended |
| done_o | output | 1 | One-cycle pulse after the final transfer |

## Verification
The bench aims at the timing corners of the schedule. It covers a second sample that misses followed by a late poll hit, a held request meeting a bus completion, and two bus lengths. A design that counts the lead from the wrong register, or samples during the held window, would shift every later start by a cycle or insert extra starts. In edge modes the bench holds the request high after the edge. A detector that falls back to level would then keep transferring in cycle-steal mode or restart straight after the suspend flag is cleared. It also raises chip-select for a CPU access while idle, and checks that the count's final completion discards a request already held, so a leaking acknowledge or an extra transfer shows up.

// File: rtl/dma_smp_pkg.sv
package dma_smp_pkg;
  typedef enum logic [2:0] {
    SM_OFF,
    SM_POLL,
    SM_GAP,
    SM_HOLD,
    SM_RUN
  } smp_state_e;

  // cycles from a detecting sample to the start pulse
  localparam int unsigned LEAD_CYC = 3;
  localparam logic [1:0]  LEAD_LD  = 2'(LEAD_CYC - 1);
endpackage

// File: rtl/dma_smp_detect.sv
module dma_smp_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dreq_i,
  input  logic edge_mode_i,
  input  logic need_edge_i,
  output logic hit_o
);
  logic dreq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dreq_q <= 1'b0;
    else         dreq_q <= dreq_i;
  end

  assign hit_o = (edge_mode_i || need_edge_i) ? (dreq_i && !dreq_q) : dreq_i;
endmodule

// File: rtl/dma_smp_sched.sv
module dma_smp_sched
  import dma_smp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic burst_i,
  input  logic edge_i,
  input  logic load_i,
  input  logic arm_i,
  input  logic cnt_nz_i,
  input  logic nmi_i,
  input  logic flag_clr_i,
  input  logic eng_busy_i,
  input  logic bus_ok_i,
  input  logic last_i,
  output logic take_o,
  output logic run_o,
  output logic need_edge_o,
  output logic flag_o
);
  smp_state_e state_q, state_d;
  logic flag_q, flag_d, need_q, need_d;

  always_comb begin
    state_d = state_q;
    flag_d  = flag_q;
    need_d  = need_q;
    take_o  = 1'b0;
    if (nmi_i) begin
      state_d = SM_OFF;
      flag_d  = 1'b1;
    end else if (load_i) begin
      state_d = (arm_i && !flag_q) ? SM_POLL : SM_OFF;
      need_d  = 1'b0;
    end else if (last_i) begin
      state_d = SM_OFF;
    end else if (flag_clr_i && flag_q) begin
      flag_d  = 1'b0;
      need_d  = 1'b1;
      state_d = cnt_nz_i ? SM_POLL : SM_OFF;
    end else begin
      unique case (state_q)
        SM_POLL: if (hit_i) begin
          take_o = 1'b1;
          need_d = 1'b0;
          if (burst_i && edge_i) state_d = SM_RUN;
          else if (eng_busy_i)   state_d = SM_HOLD;
          else                   state_d = SM_GAP;
        end
        SM_GAP:  state_d = SM_POLL;
        SM_HOLD: if (bus_ok_i) state_d = SM_POLL;
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SM_OFF;
      flag_q  <= 1'b0;
      need_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      flag_q  <= flag_d;
      need_q  <= need_d;
    end
  end

  assign run_o       = (state_q == SM_RUN);
  assign need_edge_o = need_q;
  assign flag_o      = flag_q;

  // R3
  gap_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SM_GAP) |=> (state_q != SM_GAP));
  // R12
  no_take_suspended_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q |-> !take_o);
endmodule

// File: rtl/dma_smp_engine.sv
module dma_smp_engine
  import dma_smp_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             nmi_i,
  input  logic             bus_done_i,
  output logic             start_o,
  output logic             bus_act_o,
  output logic             cnt_nz_o,
  output logic             eng_busy_o,
  output logic             bus_ok_o,
  output logic             last_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       dly_q;
  logic             pend_q, start_q, bus_q, done_q, fire;

  assign bus_ok_o = bus_done_i && bus_q;
  assign last_o   = bus_ok_o && (cnt_q == CNT_W'(1));
  assign fire     = pend_q && (dly_q <= 2'd1) && !start_q && !bus_q && !nmi_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      dly_q   <= '0;
      pend_q  <= 1'b0;
      start_q <= 1'b0;
      bus_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (load_i)                      cnt_q <= count_i;
      else if (bus_ok_o && cnt_q != 0) cnt_q <= cnt_q - 1'b1;

      // a new hit wins over the slot being consumed by fire
      if (nmi_i || load_i || last_o) pend_q <= 1'b0;
      else if (take_i)                pend_q <= 1'b1;
      else if (run_i && bus_ok_o)     pend_q <= 1'b1;
      else if (fire)                  pend_q <= 1'b0;

      if (nmi_i || load_i)  dly_q <= '0;
      else if (take_i)      dly_q <= LEAD_LD;
      else if (dly_q != 0)  dly_q <= dly_q - 1'b1;

      start_q <= fire;
      if (start_q)         bus_q <= 1'b1;
      else if (bus_done_i) bus_q <= 1'b0;
      done_q <= last_o;
    end
  end

  assign start_o    = start_q;
  assign bus_act_o  = bus_q;
  assign cnt_nz_o   = (cnt_q != 0);
  assign eng_busy_o = pend_q || start_q || bus_q;
  assign done_o     = done_q;

  // R2
  start_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |=> !start_q);
  // R9
  start_opens_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |=> bus_q);
  // R11
  done_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (cnt_q == '0));
  // R12
  nmi_blocks_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_i |=> !start_q);
endmodule

// File: rtl/dma_req_sampler.sv
module dma_req_sampler #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dreq_i,
  input  logic             burst_mode_i,
  input  logic             edge_mode_i,
  input  logic             count_load_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             bus_done_i,
  input  logic             cs_i,
  input  logic             nmi_i,
  input  logic             flag_clr_i,
  output logic             xfer_start_o,
  output logic             ack_o,
  output logic             busy_o,
  output logic             done_o
);
  logic hit, need_edge, take, run, flag;
  logic cnt_nz, eng_busy, bus_ok, last, bus_act, arm;

  assign arm = count_load_i && (count_i != '0);

  dma_smp_detect u_detect (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dreq_i      (dreq_i),
    .edge_mode_i (edge_mode_i),
    .need_edge_i (need_edge),
    .hit_o       (hit)
  );

  dma_smp_sched u_sched (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hit_i       (hit),
    .burst_i     (burst_mode_i),
    .edge_i      (edge_mode_i),
    .load_i      (count_load_i),
    .arm_i       (arm),
    .cnt_nz_i    (cnt_nz),
    .nmi_i       (nmi_i),
    .flag_clr_i  (flag_clr_i),
    .eng_busy_i  (eng_busy),
    .bus_ok_i    (bus_ok),
    .last_i      (last),
    .take_o      (take),
    .run_o       (run),
    .need_edge_o (need_edge),
    .flag_o      (flag)
  );

  dma_smp_engine #(.CNT_W(CNT_W)) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_i     (take),
    .run_i      (run),
    .load_i     (count_load_i),
    .count_i    (count_i),
    .nmi_i      (nmi_i),
    .bus_done_i (bus_done_i),
    .start_o    (xfer_start_o),
    .bus_act_o  (bus_act),
    .cnt_nz_o   (cnt_nz),
    .eng_busy_o (eng_busy),
    .bus_ok_o   (bus_ok),
    .last_o     (last),
    .done_o     (done_o)
  );

  assign ack_o  = cs_i && bus_act;
  assign busy_o = cnt_nz && !flag;

  // R11
  done_drops_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !count_load_i) |-> !busy_o);
endmodule

// File: tb/dma_req_sampler_tb.sv
module dma_req_sampler_tb;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic dreq_i = 1'b0, burst_mode_i = 1'b0, edge_mode_i = 1'b0;
  logic count_load_i = 1'b0;
  logic [CNT_W-1:0] count_i = '0;
  logic nmi_i = 1'b0, flag_clr_i = 1'b0;
  logic cs_i, bus_done_i;
  logic xfer_start_o, ack_o, busy_o, done_o;

  logic dma_cs = 1'b0, dma_done = 1'b0, cpu_cs = 1'b0;
  int   bcnt = 0;
  int   bus_len = 3;
  int   cyc = 0;
  int   checks = 0, errors = 0;
  int   exp_start[$];
  int   exp_done[$];
  string cur_req = "R2";
  int   popped;

  assign cs_i       = dma_cs || cpu_cs;
  assign bus_done_i = dma_done;

  always #10 clk = ~clk;

  dma_req_sampler #(.CNT_W(CNT_W)) u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .dreq_i       (dreq_i),
    .burst_mode_i (burst_mode_i),
    .edge_mode_i  (edge_mode_i),
    .count_load_i (count_load_i),
    .count_i      (count_i),
    .bus_done_i   (bus_done_i),
    .cs_i         (cs_i),
    .nmi_i        (nmi_i),
    .flag_clr_i   (flag_clr_i),
    .xfer_start_o (xfer_start_o),
    .ack_o        (ack_o),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // bus model: chip-select for bus_len cycles after each start
  always @(negedge clk) begin
    if (!rst_ni) begin
      bcnt = 0; dma_cs = 1'b0; dma_done = 1'b0;
    end else begin
      if (bcnt > 0) begin
        dma_cs = 1'b1; dma_done = (bcnt == 1); bcnt--;
      end else begin
        dma_cs = 1'b0; dma_done = 1'b0;
      end
      if (xfer_start_o) bcnt = bus_len;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    #5;
    if (rst_ni) begin
      if (xfer_start_o) begin
        if (exp_start.size() == 0) chk(1'b0, cur_req, cyc, -1);
        else begin
          popped = exp_start.pop_front();
          chk(cyc == popped, cur_req, cyc, popped);
        end
      end
      if (done_o) begin
        if (exp_done.size() == 0) chk(1'b0, "R11 done", cyc, -1);
        else begin
          popped = exp_done.pop_front();
          chk(cyc == popped, "R11 done", cyc, popped);
        end
      end
      if (ack_o || cs_i) chk(ack_o == dma_cs, "R9 ack", int'(ack_o), int'(dma_cs));
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic at_cycle(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic load_cnt(input int n);
    @(negedge clk);
    count_load_i = 1'b1; count_i = CNT_W'(n);
    @(negedge clk);
    count_load_i = 1'b0;
    chk(busy_o == 1'b1, "R10 busy after load", int'(busy_o), 1);
  endtask

  task automatic drain(input string req);
    chk(exp_start.size() == 0, req, exp_start.size(), 0);
    chk(exp_done.size() == 0, "R11 done drained", exp_done.size(), 0);
  endtask

  // continuous level request, n transfers
  task automatic run_level(input bit burst, input int len, input int n, input string req);
    int c;
    burst_mode_i = burst; edge_mode_i = 1'b0; bus_len = len; cur_req = req;
    load_cnt(n);
    step(1);
    c = cyc;
    for (int k = 0; k < n; k++) exp_start.push_back(c + 3 + k * (len + 2));
    exp_done.push_back(c + 3 + (n - 1) * (len + 2) + len + 1);
    dreq_i = 1'b1;
    at_cycle(c + 3 + (n - 1) * (len + 2) + len + 3);
    chk(busy_o == 1'b0, "R11 busy after done", int'(busy_o), 0);
    step(8);            // request still high: must be ignored
    dreq_i = 1'b0;
    step(3);
    drain(req);
  endtask

  int c;

  initial begin
    step(3);
    rst_ni = 1'b1;
    step(1);
    // R14
    chk(xfer_start_o == 1'b0, "R14 start", int'(xfer_start_o), 0);
    chk(ack_o == 1'b0, "R14 ack", int'(ack_o), 0);
    chk(busy_o == 1'b0, "R14 busy", int'(busy_o), 0);
    chk(done_o == 1'b0, "R14 done", int'(done_o), 0);

    // R1 R2 R4: cycle-steal, level, bus length 3
    run_level(1'b0, 3, 3, "R1 R2 R4");
    // R5 R6: burst with level detection, bus length 1
    run_level(1'b1, 1, 3, "R5 R6");

    // R3: second sample misses, later poll hit
    burst_mode_i = 1'b0; edge_mode_i = 1'b0; bus_len = 3; cur_req = "R3";
    load_cnt(2);
    step(1);
    c = cyc;
    exp_start.push_back(c + 3);
    exp_start.push_back(c + 11);
    exp_done.push_back(c + 15);
    dreq_i = 1'b1;
    step(1);
    dreq_i = 1'b0;
    at_cycle(c + 8);
    dreq_i = 1'b1;
    at_cycle(c + 20);
    dreq_i = 1'b0;
    step(2);
    drain("R3");

    // R8: cycle-steal edge, held level does not retrigger
    burst_mode_i = 1'b0; edge_mode_i = 1'b1; bus_len = 2; cur_req = "R8";
    load_cnt(2);
    step(1);
    c = cyc;
    exp_start.push_back(c + 3);
    exp_start.push_back(c + 14);
    exp_done.push_back(c + 17);
    dreq_i = 1'b1;
    at_cycle(c + 10);
    dreq_i = 1'b0;
    step(1);
    dreq_i = 1'b1;
    at_cycle(c + 24);
    dreq_i = 1'b0;
    step(2);
    drain("R8");

    // R7: burst edge, single pulse drives all transfers
    burst_mode_i = 1'b1; edge_mode_i = 1'b1; bus_len = 2; cur_req = "R7";
    load_cnt(4);
    step(1);
    c = cyc;
    for (int k = 0; k < 4; k++) exp_start.push_back(c + 3 + k * 4);
    exp_done.push_back(c + 18);
    dreq_i = 1'b1;
    step(1);
    dreq_i = 1'b0;
    at_cycle(c + 24);
    drain("R7");

    // R9: CPU chip-select while idle must not acknowledge
    cpu_cs = 1'b1;
    step(2);
    cpu_cs = 1'b0;
    step(1);

    // R12 R13: suspend during burst edge, restart on fresh edge
    burst_mode_i = 1'b1; edge_mode_i = 1'b1; bus_len = 3; cur_req = "R12";
    load_cnt(5);
    step(1);
    c = cyc;
    exp_start.push_back(c + 3);
    dreq_i = 1'b1;
    step(1);
    dreq_i = 1'b0;
    at_cycle(c + 5);
    nmi_i = 1'b1;
    step(1);
    nmi_i = 1'b0;
    at_cycle(c + 8);
    chk(busy_o == 1'b0, "R12 busy while suspended", int'(busy_o), 0);
    at_cycle(c + 9);
    dreq_i = 1'b1;       // edge while suspended, ignored
    at_cycle(c + 11);
    cur_req = "R13";
    flag_clr_i = 1'b1;
    step(1);
    flag_clr_i = 1'b0;
    step(1);
    chk(busy_o == 1'b1, "R13 busy after clear", int'(busy_o), 1);
    at_cycle(c + 20);
    chk(exp_start.size() == 0, "R13 no restart on held level", exp_start.size(), 0);
    dreq_i = 1'b0;
    step(1);
    for (int k = 0; k < 4; k++) exp_start.push_back(c + 24 + k * 5);
    exp_done.push_back(c + 43);
    dreq_i = 1'b1;
    step(1);
    dreq_i = 1'b0;
    at_cycle(c + 50);
    chk(busy_o == 1'b0, "R11 busy after final", int'(busy_o), 0);
    drain("R13");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule